// File: doc/BRIEF.md
# Bitmap Overlay with Banked CPU Window

This block adds a one-bit-per-pixel bitmap plane on top of a character-mapped text display. The bitmap lives in a private byte RAM. The host CPU does not see the whole store at once. It reaches the store through a small address window whose upper RAM address bits come from a bank register. A second register selects how the bitmap combines with the text dots: text only, AND, OR or XOR.

During active display, the video timing chain supplies a byte column, a scanline and a dot count within the byte. Once per byte, in the dot-0 slot, the block reads the matching bitmap byte. It then shifts the byte out MSB first, one pixel per clock, and combines each pixel with the incoming text pixel. A wide/narrow input selects the pixel width. In wide mode a bitmap line is 2^COL_BITS bytes. In narrow mode (the 32-column text mode) a line is half that width, and only the low half of the store is used.

The CPU and the video path share the single RAM port through a two-way address multiplexer. Video always owns the dot-0 fetch slot, and a CPU window access that arrives in that slot moves to the next clock. The defaults give an 8-bank, 256-byte window over a 2 KB store with 32 lines. The setting WIN_BITS=11, LINE_BITS=8 gives a 16 KB store with a 2 KB window at 0xE000–0xE7FF and a 512×256 picture.

Top module: `bmp_overlay`

## Requirements
- R1: After reset the bank register and the mix mode read back as 0, and pixOut and cpuRdy are 0.
- R2: A CPU access with cpuAddr inside the window (cpuAddr[15:WIN_BITS] equal to WIN_BASE[15:WIN_BITS]) reaches RAM byte bank·2^WIN_BITS + cpuAddr[WIN_BITS-1:0]. A read returns the byte last written there.
- R3: A write to CTL_BASE stores cpuWrData[2:0] as the bank. A read of CTL_BASE returns the bank in bits 2:0, with bits 7:3 zero.
- R4: A write to CTL_BASE+1 stores cpuWrData[1:0] as the mix mode: 00 text only, 01 AND, 10 OR, 11 XOR. A read of CTL_BASE+1 returns the mode in bits 1:0, with the other bits zero.
- R5: pixOut in a cycle equals mix(mode, bitmap pixel, textPix of the previous cycle). The bitmap pixel is the one for the video counters driven three cycles earlier.
- R6: Dot k (0..7) of a byte shows bit 7−k of the fetched byte (MSB first).
- R7: With wideMode=1 the byte fetched is line·2^COL_BITS + col. With wideMode=0 it is line·2^(COL_BITS−1) + col[COL_BITS−2:0].
- R8: A byte whose dot-0 cycle has dispActive=0 gives bitmap pixels of 0 for all eight dots.
- R9: cpuRdy rises one cycle after cpuCs is first seen. A window access seen in a fetch slot (dispActive=1 and dotCnt=0) is delayed by exactly one further cycle. A register access is never delayed.
- R10: cpuRdy is a one-cycle pulse. While cpuCs stays high after it, no further access and no further pulse occur.
- R11: An access with cpuCs high to an address outside the window and both registers completes with read data 0 and changes nothing. Bus activity with cpuCs low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpuCs | input | 1 | Chip select, held until cpuRdy |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | CPU read data, valid while cpuRdy |
| cpuRdy | output | 1 | Access complete (one-cycle pulse) |
| wideMode | input | 1 | 1 = wide (64-column) geometry, 0 = narrow |
| dispActive | input | 1 | Video in the active picture |
| colIdx | input | COL_BITS | Byte column from the timing chain |
| lineIdx | input | LINE_BITS | Scanline from the timing chain |
| dotCnt | input | 3 | Dot within the current byte |
| textPix | input | 1 | Text pixel stream |
| pixOut | output | 1 | Mixed pixel |

## Verification
A pixel is due three cycles after the counters that address it: one cycle for the RAM read, one for the shifter load and one for the output register. The text pixel it mixes with is the one driven one cycle before the output. The bench keeps a three-deep history of expected bitmap bits and a one-deep history of text bits, and compares each sampled pixOut against those entries. It pauses the comparison whenever the mode changes. For CPU accesses, the bench records at the next rising edge whether that cycle was a fetch slot. It then expects cpuRdy after one falling edge, or after two for a window access that met the slot.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int PIX_PER_BYTE = 8;

  typedef enum logic [1:0] {MIX_OFF = 2'b00, MIX_AND = 2'b01, MIX_OR = 2'b10, MIX_XOR = 2'b11} mix_e;

  typedef enum logic [1:0] {ST_IDLE, ST_DONE, ST_HOLD} busSt_e;

  typedef enum logic [1:0] {RD_ZERO, RD_RAM, RD_BANK, RD_MODE} rdSel_e;

  typedef struct packed {
    logic   cpuRam;
    logic   cpuWr;
    logic   bankWr;
    logic   modeWr;
    logic   vidFetch;
    logic   shLoad;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
#(
  parameter int          WIN_BITS = 8,
  parameter logic [15:0] WIN_BASE = 16'hE000,
  parameter logic [15:0] CTL_BASE = 16'hE800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpuCs,
  input  logic        cpuWe,
  input  logic [15:0] cpuAddr,
  input  logic        dispActive,
  input  logic [2:0]  dotCnt,
  output strobe_t     strb,
  output logic        cpuRdy
);
  localparam logic [15:0] MODE_ADDR = CTL_BASE + 16'd1;

  busSt_e state;
  rdSel_e rdSelQ;
  logic   hitWin, hitBank, hitMode, vidSlot, go;

  assign hitWin  = cpuAddr[15:WIN_BITS] == WIN_BASE[15:WIN_BITS];
  assign hitBank = cpuAddr == CTL_BASE;
  assign hitMode = cpuAddr == MODE_ADDR;
  assign vidSlot = dispActive && (dotCnt == 3'd0);
  assign go      = (state == ST_IDLE) && cpuCs && !(hitWin && vidSlot);

  always_comb begin
    strb.cpuRam   = go && hitWin;
    strb.cpuWr    = go && hitWin && cpuWe;
    strb.bankWr   = go && hitBank && cpuWe;
    strb.modeWr   = go && hitMode && cpuWe;
    strb.vidFetch = vidSlot;
    strb.shLoad   = dotCnt == 3'd1;
    strb.rdSel    = rdSelQ;
  end

  assign cpuRdy = state == ST_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rdSelQ <= RD_ZERO;
    end else begin
      unique case (state)
        ST_IDLE: if (go) begin
          state <= ST_DONE;
          if (cpuWe)        rdSelQ <= RD_ZERO;
          else if (hitWin)  rdSelQ <= RD_RAM;
          else if (hitBank) rdSelQ <= RD_BANK;
          else if (hitMode) rdSelQ <= RD_MODE;
          else              rdSelQ <= RD_ZERO;
        end
        ST_DONE: state <= cpuCs ? ST_HOLD : ST_IDLE;
        ST_HOLD: if (!cpuCs) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ovl_datapath.sv
module ovl_datapath
  import ovl_pkg::*;
#(
  parameter int COL_BITS  = 6,
  parameter int LINE_BITS = 5,
  parameter int WIN_BITS  = 8,
  parameter int BANK_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              strb,
  input  logic [WIN_BITS-1:0]  cpuOfs,
  input  logic [7:0]           cpuWrData,
  output logic [7:0]           cpuRdData,
  input  logic                 wideMode,
  input  logic [COL_BITS-1:0]  colIdx,
  input  logic [LINE_BITS-1:0] lineIdx,
  input  logic                 textPix,
  output logic                 pixOut,
  output logic [1:0]           modeQ
);
  localparam int RAM_AW = WIN_BITS + BANK_BITS;
  localparam int DEPTH  = 1 << RAM_AW;

  logic [PIX_PER_BYTE-1:0] mem [DEPTH];
  logic [PIX_PER_BYTE-1:0] ramQ, shReg;
  logic [BANK_BITS-1:0]    bankQ;
  logic [RAM_AW-1:0]       vidAddr, ramAddr;
  logic                    fetchValid, bmpBit, mixed;

  assign vidAddr = wideMode ? RAM_AW'({lineIdx, colIdx})
                            : RAM_AW'({lineIdx, colIdx[COL_BITS-2:0]});
  assign ramAddr = strb.cpuRam ? {bankQ, cpuOfs} : vidAddr;

  always_ff @(posedge clk) begin
    if (strb.cpuWr) mem[ramAddr] <= cpuWrData;
    if ((strb.cpuRam && !strb.cpuWr) || strb.vidFetch) ramQ <= mem[ramAddr];
  end

  assign bmpBit = shReg[PIX_PER_BYTE-1];

  always_comb begin
    unique case (mix_e'(modeQ))
      MIX_AND: mixed = bmpBit & textPix;
      MIX_OR:  mixed = bmpBit | textPix;
      MIX_XOR: mixed = bmpBit ^ textPix;
      default: mixed = textPix;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bankQ      <= '0;
      modeQ      <= MIX_OFF;
      fetchValid <= 1'b0;
      shReg      <= '0;
      pixOut     <= 1'b0;
    end else begin
      if (strb.bankWr) bankQ <= cpuWrData[BANK_BITS-1:0];
      if (strb.modeWr) modeQ <= cpuWrData[1:0];
      fetchValid <= strb.vidFetch;
      if (strb.shLoad) shReg <= fetchValid ? ramQ : '0;
      else             shReg <= shReg << 1;
      pixOut <= mixed;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_RAM:  cpuRdData = ramQ;
      RD_BANK: cpuRdData = 8'(bankQ);
      RD_MODE: cpuRdData = 8'(modeQ);
      default: cpuRdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/bmp_overlay.sv
module bmp_overlay
  import ovl_pkg::*;
#(
  parameter int          COL_BITS  = 6,
  parameter int          LINE_BITS = 5,
  parameter int          WIN_BITS  = 8,
  parameter int          BANK_BITS = 3,
  parameter logic [15:0] WIN_BASE  = 16'hE000,
  parameter logic [15:0] CTL_BASE  = 16'hE800
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpuCs,
  input  logic                 cpuWe,
  input  logic [15:0]          cpuAddr,
  input  logic [7:0]           cpuWrData,
  output logic [7:0]           cpuRdData,
  output logic                 cpuRdy,
  input  logic                 wideMode,
  input  logic                 dispActive,
  input  logic [COL_BITS-1:0]  colIdx,
  input  logic [LINE_BITS-1:0] lineIdx,
  input  logic [2:0]           dotCnt,
  input  logic                 textPix,
  output logic                 pixOut
);
  strobe_t    strb;
  logic [1:0] modeQ;

  ovl_ctrl #(
    .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE), .CTL_BASE(CTL_BASE)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cpuCs(cpuCs), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .dispActive(dispActive), .dotCnt(dotCnt), .strb(strb), .cpuRdy(cpuRdy)
  );

  ovl_datapath #(
    .COL_BITS(COL_BITS), .LINE_BITS(LINE_BITS), .WIN_BITS(WIN_BITS), .BANK_BITS(BANK_BITS)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cpuOfs(cpuAddr[WIN_BITS-1:0]),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .wideMode(wideMode),
    .colIdx(colIdx), .lineIdx(lineIdx), .textPix(textPix), .pixOut(pixOut), .modeQ(modeQ)
  );
endmodule

// File: rtl/bmp_overlay_chk.sv
module bmp_overlay_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpuCs,
  input logic       cpuRdy,
  input logic       dispActive,
  input logic [2:0] dotCnt,
  input logic       textPix,
  input logic       pixOut,
  input logic [1:0] modeQ,
  input logic       cpuRamGo
);
  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpuRdy |=> !cpuRdy); // R10

  AST_RDY_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cpuRdy |-> $past(cpuCs)); // R9

  AST_VIDEO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (dispActive && dotCnt == 3'd0) |-> !cpuRamGo); // R9

  AST_MIX_OFF_TEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(modeQ) == 2'b00) |-> (pixOut == $past(textPix))); // R5

  AST_MIX_AND_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(modeQ) == 2'b01 && !$past(textPix)) |-> !pixOut); // R5

  AST_MIX_OR_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(modeQ) == 2'b10 && $past(textPix)) |-> pixOut); // R5
endmodule

bind bmp_overlay bmp_overlay_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpuCs(cpuCs), .cpuRdy(cpuRdy),
  .dispActive(dispActive), .dotCnt(dotCnt), .textPix(textPix),
  .pixOut(pixOut), .modeQ(modeQ), .cpuRamGo(strb.cpuRam)
);

// File: tb/bmp_overlay_tb_top.sv
module bmp_overlay_tb_top;
  localparam int COL_BITS  = 6;
  localparam int LINE_BITS = 5;
  localparam int WIN_BITS  = 8;
  localparam int BANK_BITS = 3;
  localparam int WIN_SIZE  = 1 << WIN_BITS;
  localparam int NBANKS    = 1 << BANK_BITS;
  localparam int RAM_BYTES = WIN_SIZE * NBANKS;
  localparam logic [15:0] WIN_BASE = 16'hE000;
  localparam logic [15:0] CTL_BASE = 16'hE800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpuCs = 1'b0, cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData;
  logic cpuRdy;
  logic wideMode = 1'b1, dispActive = 1'b0, textPix = 1'b0;
  logic [COL_BITS-1:0] colIdx = '0;
  logic [LINE_BITS-1:0] lineIdx = '0;
  logic [2:0] dotCnt = 3'd7;
  logic pixOut;

  int testCnt = 0, failCnt = 0;
  logic [7:0] mirror [RAM_BYTES];
  logic [1:0] modeShadow = 2'b00;
  bit vidRun = 0, checkEn = 0;
  int histCnt = 0;
  logic bmpHist [3];
  logic textHist;
  logic [7:0] curByte = '0;

  always #2 clk = ~clk;

  bmp_overlay #(
    .COL_BITS(COL_BITS), .LINE_BITS(LINE_BITS), .WIN_BITS(WIN_BITS),
    .BANK_BITS(BANK_BITS), .WIN_BASE(WIN_BASE), .CTL_BASE(CTL_BASE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cpuCs(cpuCs), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .cpuRdy(cpuRdy),
    .wideMode(wideMode), .dispActive(dispActive), .colIdx(colIdx),
    .lineIdx(lineIdx), .dotCnt(dotCnt), .textPix(textPix), .pixOut(pixOut)
  );

  function automatic logic mixFn(input logic [1:0] m, input logic b, input logic t);
    case (m)
      2'b01:   return b & t;
      2'b10:   return b | t;
      2'b11:   return b ^ t;
      default: return t;
    endcase
  endfunction

  function automatic int vidAddrFn(input logic w, input logic [LINE_BITS-1:0] ln,
                                   input logic [COL_BITS-1:0] c);
    if (w) return int'(ln) * (1 << COL_BITS) + int'(c);
    return int'(ln) * (1 << (COL_BITS - 1)) + int'(c[COL_BITS-2:0]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  // Video timing driver and pixel checker: R5, R6, R7, R8
  always @(negedge clk) begin
    if (vidRun) begin
      if (!checkEn) histCnt = 0;
      else if (histCnt >= 3) begin
        logic e;
        e = mixFn(modeShadow, bmpHist[2], textHist);
        check(pixOut === e, "R5,R6,R7,R8 pixel", int'(pixOut), int'(e));
      end
      dotCnt = dotCnt + 3'd1;
      if (dotCnt == 3'd0) begin
        colIdx = colIdx + 1'b1;
        if (colIdx == '0) begin
          lineIdx  = lineIdx + 1'b1;
          wideMode = $urandom_range(0, 1) != 0;
        end
        dispActive = $urandom_range(0, 7) != 0;
        curByte = dispActive ? mirror[vidAddrFn(wideMode, lineIdx, colIdx)] : 8'h00;
      end
      textPix = $urandom_range(0, 1) != 0;
      bmpHist[2] = bmpHist[1];
      bmpHist[1] = bmpHist[0];
      bmpHist[0] = curByte[7 - int'(dotCnt)];
      textHist = textPix;
      if (checkEn) histCnt++;
    end
  end

  task automatic cpuXfer(input logic [15:0] a, input bit w, input logic [7:0] d,
                         input bit hold, output logic [7:0] q, output int extra);
    bit busy, inWin;
    int waits;
    extra = 0;
    inWin = a[15:WIN_BITS] == WIN_BASE[15:WIN_BITS];
    @(negedge clk);
    cpuCs = 1'b1; cpuAddr = a; cpuWe = w; cpuWrData = d;
    @(posedge clk);
    busy = dispActive && dotCnt == 3'd0;
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!cpuRdy && waits < 16);
    q = cpuRdData;
    check(waits == ((busy && inWin) ? 2 : 1), "R9 latency", waits, (busy && inWin) ? 2 : 1);
    if (hold) begin
      repeat (4) begin
        @(negedge clk);
        if (cpuRdy) extra++;
      end
    end
    cpuCs = 1'b0; cpuWe = 1'b0;
    @(negedge clk);
  endtask

  task automatic cpuWr(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] q;
    int x;
    cpuXfer(a, 1'b1, d, 1'b0, q, x);
  endtask

  task automatic cpuRd(input logic [15:0] a, output logic [7:0] q);
    int x;
    cpuXfer(a, 1'b0, 8'h00, 1'b0, q, x);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL R10 watchdog actual=200000 cycles expected=fewer");
    finishRun();
  end

  initial begin
    logic [7:0] q;
    int x;
    void'($urandom(32'd7319));
    bmpHist[0] = 0; bmpHist[1] = 0; bmpHist[2] = 0; textHist = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(pixOut === 1'b0, "R1 pixOut", int'(pixOut), 0);
    check(cpuRdy === 1'b0, "R1 cpuRdy", int'(cpuRdy), 0);
    cpuRd(CTL_BASE, q);
    check(q === 8'h00, "R1 bank", int'(q), 0);
    cpuRd(CTL_BASE + 16'd1, q);
    check(q === 8'h00, "R1 mode", int'(q), 0);

    // R3 / R4: register write and readback with upper bits masked
    cpuWr(CTL_BASE, 8'hFD);
    cpuRd(CTL_BASE, q);
    check(q === 8'h05, "R3 bank readback", int'(q), 5);
    cpuWr(CTL_BASE + 16'd1, 8'hFE);
    cpuRd(CTL_BASE + 16'd1, q);
    check(q === 8'h02, "R4 mode readback", int'(q), 2);
    cpuWr(CTL_BASE + 16'd1, 8'h00);

    // R2: fill every bank through the window
    for (int b = 0; b < NBANKS; b++) begin
      cpuWr(CTL_BASE, 8'(b));
      for (int o = 0; o < WIN_SIZE; o++) begin
        logic [7:0] d;
        d = 8'($urandom);
        mirror[b * WIN_SIZE + o] = d;
        cpuWr(WIN_BASE + 16'(o), d);
      end
    end
    for (int i = 0; i < 40; i++) begin
      int b, o;
      b = $urandom_range(0, NBANKS - 1);
      o = $urandom_range(0, WIN_SIZE - 1);
      cpuWr(CTL_BASE, 8'(b));
      cpuRd(WIN_BASE + 16'(o), q);
      check(q === mirror[b * WIN_SIZE + o], "R2 window readback", int'(q),
            int'(mirror[b * WIN_SIZE + o]));
    end

    // R11: unmapped address with cs, and bus activity without cs
    cpuWr(CTL_BASE, 8'd3);
    cpuWr(CTL_BASE + 16'd1, 8'd1);
    cpuWr(CTL_BASE + 16'd2, 8'hFF);
    cpuWr(WIN_BASE + 16'(WIN_SIZE), 8'h5A);
    cpuRd(16'hD000, q);
    check(q === 8'h00, "R11 unmapped read", int'(q), 0);
    @(negedge clk);
    cpuAddr = CTL_BASE; cpuWe = 1'b1; cpuWrData = 8'h06;
    repeat (4) @(negedge clk);
    cpuWe = 1'b0;
    cpuRd(CTL_BASE, q);
    check(q === 8'h03, "R11 bank untouched", int'(q), 3);
    cpuRd(CTL_BASE + 16'd1, q);
    check(q === 8'h01, "R11 mode untouched", int'(q), 1);
    cpuRd(WIN_BASE, q);
    check(q === mirror[3 * WIN_SIZE], "R11 ram untouched", int'(q), int'(mirror[3 * WIN_SIZE]));

    // R10: held chip select gives a single pulse
    cpuXfer(WIN_BASE + 16'd1, 1'b0, 8'h00, 1'b1, q, x);
    check(x == 0, "R10 extra pulses", x, 0);
    check(q === mirror[3 * WIN_SIZE + 1], "R10 held read data", int'(q),
          int'(mirror[3 * WIN_SIZE + 1]));
    cpuWr(CTL_BASE + 16'd1, 8'd0);

    // Streaming phases: every mode, random text, random reads during display
    vidRun = 1;
    repeat (5) @(negedge clk);
    for (int seg = 0; seg < 8; seg++) begin
      logic [1:0] m;
      m = 2'(seg);
      checkEn = 0;
      cpuWr(CTL_BASE + 16'd1, {6'd0, m});
      modeShadow = m;
      checkEn = 1;
      for (int i = 0; i < 16; i++) begin
        int b, o;
        b = $urandom_range(0, NBANKS - 1);
        o = $urandom_range(0, WIN_SIZE - 1);
        cpuWr(CTL_BASE, 8'(b));
        cpuRd(WIN_BASE + 16'(o), q);
        check(q === mirror[b * WIN_SIZE + o], "R2,R9 read during display", int'(q),
              int'(mirror[b * WIN_SIZE + o]));
        repeat ($urandom_range(0, 5)) @(negedge clk);
      end
      repeat (300) @(negedge clk);
    end
    checkEn = 0;
    finishRun();
  end
endmodule